// File: doc/BRIEF.md
# Serial Control Port with Line Alarm Interrupts

This block is the host-facing control port of a line-interface device. A host frames each transaction with an active-low chip select and clocks bits in on a serial clock, least-significant bit first. The first byte is a command: a read/write flag followed by a six-bit device address and one bit that is ignored. When the address matches the device address (16), a write takes the next eight bits as control data. A read instead shifts a status byte out on a serial data output that is only enabled during the read data phase, so the host may join the data input and data output on one bidirectional pin at the pad.

Two alarm sources, loss of signal (LOS) and output-driver monitor faults (DRV), arrive as single-cycle event pulses. Each source latches an event when it is unmasked and pulls the active-low interrupt output. Writing 1 to a source's control bit clears its latch, clears its part of the alarm code and masks the source. Writing 0 unmasks it. Reading the status never clears anything.

The serial pins are brought into the system clock domain through a synchronizer and edge detector. A six-state machine sequences each frame. Its states are IDLE (chip select inactive), CMD (command bits), WR (write data bits), RD_ARM (waiting for the first falling serial clock edge), RD (driving read data) and DONE (frame finished or ignored). Its transitions are: select asserted (IDLE to CMD); eighth command bit with address match and write flag (CMD to WR); eighth command bit with address match and read flag (CMD to RD_ARM); eighth command bit without a match (CMD to DONE); eighth data bit (WR to DONE); first falling edge (RD_ARM to RD); falling edge after the eighth data bit (RD to DONE); and select released, which returns any state to IDLE.

Top module: `line_ctl_serial_port`

## Requirements
- R1: A frame is sent LSB first, and SDI is sampled on rising SCLK edges. Command bit 0 is the direction (1 = read, 0 = write). Command bits 1 to 6 hold the address, LSB first. Command bit 7 is ignored.
- R2: Only address 16 gets a response. A frame to any other address keeps the data output disabled and changes no mask, latch or alarm.
- R3: On a write, the eight bits after the command are the control data. Data bit 0 controls LOS and data bit 1 controls DRV. Writing 1 to a source's bit clears its latch, removes it from the alarm code and masks it.
- R4: Writing 0 to a source's bit unmasks it. An event on a masked source is not latched. Data bits 2 to 7 have no effect.
- R5: The read status byte is laid out as follows. Bit 0 is the LOS mask and bit 1 is the DRV mask. Bits 4:2 are the line-length input. Bits 7:5 are the alarm code: 000 for none, 101 for LOS, 110 for DRV, 111 for both.
- R6: Reading the status never clears a latched event or the interrupt.
- R7: An event pulse on an unmasked source latches on the next clock. The interrupt output is low exactly while any latch is set.
- R8: The data output enable rises at the first falling SCLK edge after a matching read command and falls at the falling edge after the eighth data bit, or when chip select is released. SDO changes only on falling SCLK edges while selected.
- R9: Releasing chip select mid-frame aborts the frame without committing a write, and the next frame starts again at command bit 0.
- R10: After reset all sources are unmasked and nothing is latched. The interrupt is high, the output enable is low and the alarm code is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select framing a transaction |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| los_evt | input | 1 | One-cycle loss-of-signal event pulse |
| dpm_evt | input | 1 | One-cycle driver-fault event pulse |
| line_len | input | 3 | Current line-length selection, reported in status |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for the SDO pad (low = high impedance) |
| int_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that event pulses and write commits are synchronous to the system clock. They also assume SCLK and chip select change slowly enough that each serial edge is seen as a single-cycle pulse after synchronization, so SDO can only move in the cycle after a detected falling edge. The bench holds every SCLK half period for six system clocks. It changes SDI only while SCLK is low, and it toggles chip select only with SCLK low and a margin of several clocks. Event pulses are driven away from write commits, so the same-cycle priority between clear and event is never relied on at the ports.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    localparam int LSP_DATA_W = 8;
    localparam int LSP_NSRC   = 2;
    localparam int LSP_LEN_W  = LSP_DATA_W - LSP_NSRC - 3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CMD    = 3'd1,
        ST_WR     = 3'd2,
        ST_RD_ARM = 3'd3,
        ST_RD     = 3'd4,
        ST_DONE   = 3'd5
    } lsp_state_e;

endpackage

// File: rtl/lsp_sync.sv
module lsp_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/lsp_edge_det.sv
module lsp_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

endmodule

// File: rtl/lsp_frame_fsm.sv
module lsp_frame_fsm
    import lsp_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DEV_ADDR = 16,
    parameter int DATA_W   = 8,
    parameter int KEEP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_bit,
    input  logic [DATA_W-1:0] status_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              wr_stb,
    output logic [KEEP_W-1:0] wr_bits
);

    localparam int CMD_W    = ADDR_W + 2;
    localparam int CMD_KEEP = ADDR_W + 1;
    localparam int MAX_W    = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W    = $clog2(MAX_W + 1);

    lsp_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [CMD_KEEP-1:0] cmd_q, cmd_now;
    logic [KEEP_W-1:0]   keep_q, keep_now;
    logic [DATA_W-1:0]   rsh_q;
    logic                oe_q;
    logic                stb_q;

    logic                last_cmd;
    logic                last_dat;
    logic                rd_done;
    logic                is_read;
    logic                addr_hit;

    always_comb begin
        cmd_now = cmd_q;
        for (int i = 0; i < CMD_KEEP; i++) begin
            if (cnt_q == CNT_W'(i)) cmd_now[i] = sdi_bit;
        end
        keep_now = keep_q;
        for (int i = 0; i < KEEP_W; i++) begin
            if (cnt_q == CNT_W'(i)) keep_now[i] = sdi_bit;
        end
    end

    assign last_cmd = (cnt_q == CNT_W'(CMD_W - 1));
    assign last_dat = (cnt_q == CNT_W'(DATA_W - 1));
    assign rd_done  = (cnt_q == CNT_W'(DATA_W));
    assign is_read  = cmd_now[0];
    assign addr_hit = (cmd_now[ADDR_W:1] == ADDR_W'(DEV_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_act) state_d = ST_CMD;
            ST_CMD: begin
                if (sclk_rise && last_cmd) begin
                    if (!addr_hit)    state_d = ST_DONE;
                    else if (is_read) state_d = ST_RD_ARM;
                    else              state_d = ST_WR;
                end
            end
            ST_WR:     if (sclk_rise && last_dat) state_d = ST_DONE;
            ST_RD_ARM: if (sclk_fall) state_d = ST_RD;
            ST_RD:     if (sclk_fall && rd_done) state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
        if (!cs_act) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmd_q  <= '0;
            keep_q <= '0;
            rsh_q  <= '0;
            oe_q   <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (!cs_act) begin
                cnt_q <= '0;
                cmd_q <= '0;
                oe_q  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        cnt_q <= '0;
                        cmd_q <= '0;
                    end
                    ST_CMD: begin
                        if (sclk_rise) begin
                            cmd_q <= cmd_now;
                            cnt_q <= last_cmd ? '0 : cnt_q + 1'b1;
                        end
                    end
                    ST_WR: begin
                        if (sclk_rise) begin
                            keep_q <= keep_now;
                            cnt_q  <= cnt_q + 1'b1;
                            if (last_dat) stb_q <= 1'b1;
                        end
                    end
                    ST_RD_ARM: begin
                        if (sclk_fall) begin
                            rsh_q <= status_word;
                            oe_q  <= 1'b1;
                            cnt_q <= '0;
                        end
                    end
                    ST_RD: begin
                        if (sclk_rise) cnt_q <= cnt_q + 1'b1;
                        if (sclk_fall) begin
                            if (rd_done) oe_q  <= 1'b0;
                            else         rsh_q <= {1'b0, rsh_q[DATA_W-1:1]};
                        end
                    end
                    ST_DONE: cnt_q <= cnt_q;
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign sdo     = rsh_q[0] & oe_q;
    assign sdo_oe  = oe_q;
    assign wr_stb  = stb_q;
    assign wr_bits = keep_q;

endmodule

// File: rtl/lsp_irq_bank.sv
module lsp_irq_bank #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            wr_stb,
    input  logic [NSRC-1:0] wr_bits,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] lat_o
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic m_q;
        logic l_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_q <= 1'b0;
                l_q <= 1'b0;
            end else if (wr_stb && wr_bits[g]) begin
                m_q <= 1'b1;
                l_q <= 1'b0;
            end else begin
                if (wr_stb)           m_q <= 1'b0;
                if (evt[g] && !m_q)   l_q <= 1'b1;
            end
        end

        assign mask_o[g] = m_q;
        assign lat_o[g]  = l_q;
    end

endmodule

// File: rtl/line_ctl_serial_port.sv
module line_ctl_serial_port
    import lsp_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DEV_ADDR    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 sdi,
    input  logic                 los_evt,
    input  logic                 dpm_evt,
    input  logic [LSP_LEN_W-1:0] line_len,
    output logic                 sdo,
    output logic                 sdo_oe,
    output logic                 int_n
);

    logic [2:0]            pin_raw, pin_sync;
    logic                  cs_act;
    logic                  sclk_rise, sclk_fall;
    logic                  wr_stb;
    logic [LSP_NSRC-1:0]   wr_bits;
    logic [LSP_NSRC-1:0]   src_mask, src_lat;
    logic [2:0]            alarm_code;
    logic [LSP_DATA_W-1:0] status_word;

    assign pin_raw = {sdi, sclk, cs_n};

    lsp_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (pin_raw),
        .d_out(pin_sync)
    );

    assign cs_act = ~pin_sync[0];

    lsp_edge_det u_sclk_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(pin_sync[1]),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    assign alarm_code  = {|src_lat, src_lat[1], src_lat[0]};
    assign status_word = {alarm_code, line_len, src_mask};

    lsp_frame_fsm #(
        .ADDR_W  (ADDR_W),
        .DEV_ADDR(DEV_ADDR),
        .DATA_W  (LSP_DATA_W),
        .KEEP_W  (LSP_NSRC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .sdi_bit    (pin_sync[2]),
        .status_word(status_word),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .wr_stb     (wr_stb),
        .wr_bits    (wr_bits)
    );

    lsp_irq_bank #(
        .NSRC(LSP_NSRC)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    ({dpm_evt, los_evt}),
        .wr_stb (wr_stb),
        .wr_bits(wr_bits),
        .mask_o (src_mask),
        .lat_o  (src_lat)
    );

    assign int_n = ~|src_lat;

endmodule

// File: rtl/line_ctl_serial_port_chk.sv
module line_ctl_serial_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_act,
    input logic       sclk_fall,
    input logic       sdo,
    input logic       sdo_oe,
    input logic       int_n,
    input logic       los_evt,
    input logic       dpm_evt,
    input logic       wr_stb,
    input logic [1:0] wr_bits,
    input logic [1:0] src_mask,
    input logic [1:0] src_lat
);

    assert_release_quiets_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdo_oe);

    assert_sdo_moves_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && cs_act) |=> $stable(sdo));

    assert_los_raises_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (los_evt && !src_mask[0] && !wr_stb) |=> !int_n);

    assert_dpm_raises_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dpm_evt && !src_mask[1] && !wr_stb) |=> !int_n);

    assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lat[0] && !wr_stb) |=> src_lat[0]);

    assert_clear_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_bits[0]) |=> (src_mask[0] && !src_lat[0]));

    assert_zero_unmasks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_bits[1]) |=> !src_mask[1]);

endmodule

bind line_ctl_serial_port line_ctl_serial_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .sclk_fall(sclk_fall),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .int_n    (int_n),
    .los_evt  (los_evt),
    .dpm_evt  (dpm_evt),
    .wr_stb   (wr_stb),
    .wr_bits  (wr_bits),
    .src_mask (src_mask),
    .src_lat  (src_lat)
);

// File: tb/line_ctl_serial_port_bench.sv
module line_ctl_serial_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       los_evt = 1'b0;
    logic       dpm_evt = 1'b0;
    logic [2:0] line_len = 3'd0;
    logic       sdo, sdo_oe, int_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    bit  m_lat  [2];
    bit  m_mask [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    line_ctl_serial_port u_line_ctl_serial_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .sdi     (sdi),
        .los_evt (los_evt),
        .dpm_evt (dpm_evt),
        .line_len(line_len),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe),
        .int_n   (int_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_status();
        int s;
        s = {29'd0, (m_lat[0] | m_lat[1])} << 7;
        s = s | (int'(m_lat[1]) << 6) | (int'(m_lat[0]) << 5);
        s = s | (int'(line_len) << 2) | (int'(m_mask[1]) << 1) | int'(m_mask[0]);
        return s;
    endfunction

    function automatic int exp_int();
        return (m_lat[0] | m_lat[1]) ? 0 : 1;
    endfunction

    task automatic frame(input logic [7:0] cmd, input logic [7:0] wd, input int nbits,
                         output logic [7:0] rd, output int oe_cmd, output int oe_dat,
                         output int oe_end);
        rd = '0; oe_cmd = 0; oe_dat = 0;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 8) ? cmd[i] : wd[i-8];
            repeat (HALF) @(negedge clk);
            if (i < 8) oe_cmd += int'(sdo_oe);
            else begin
                rd[i-8] = sdo;
                oe_dat += int'(sdo_oe);
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        oe_end = int'(sdo_oe);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic read_check(input string req, input logic [7:0] cmd);
        logic [7:0] rd;
        int a, b, c;
        frame(cmd, 8'h00, 16, rd, a, b, c);
        chk("R8", "oe during command", a, 0);
        chk("R8", "oe during read data", b, 8);
        chk("R8", "oe after last fall", c, 0);
        chk(req, "status byte", int'(rd), exp_status());
    endtask

    task automatic write_ctl(input logic [7:0] d);
        logic [7:0] rd;
        int a, b, c;
        frame({1'b0, 6'd16, 1'b0}, d, 16, rd, a, b, c);
        chk("R8", "oe in write frame", a + b + c, 0);
        for (int s = 0; s < 2; s++) begin
            if (d[s]) begin
                m_lat[s]  = 1'b0;
                m_mask[s] = 1'b1;
            end else begin
                m_mask[s] = 1'b0;
            end
        end
    endtask

    task automatic pulse(input bit l, input bit d);
        los_evt = l;
        dpm_evt = d;
        @(negedge clk);
        los_evt = 1'b0;
        dpm_evt = 1'b0;
        if (l && !m_mask[0]) m_lat[0] = 1'b1;
        if (d && !m_mask[1]) m_lat[1] = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int a, b, c;
        for (int s = 0; s < 2; s++) begin
            m_lat[s]  = 1'b0;
            m_mask[s] = 1'b0;
        end
        repeat (5) @(negedge clk);
        chk("R10", "int_n in reset", int'(int_n), 1);
        chk("R10", "oe in reset", int'(sdo_oe), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", "int_n after reset", int'(int_n), 1);
        read_check("R10", {1'b0, 6'd16, 1'b1});

        // R1 R2: sweep every address with a read command
        for (int ad = 0; ad < 64; ad++) begin
            line_len = 3'(ad);
            frame({1'b0, 6'(ad), 1'b1}, 8'h00, 16, rd, a, b, c);
            if (ad == 16) begin
                chk("R1", "own address answers", b, 8);
                chk("R1", "status at own address", int'(rd), exp_status());
            end else begin
                chk("R2", "foreign address output enable", a + b + c, 0);
            end
        end

        // R1: command bit 7 ignored
        line_len = 3'd5;
        read_check("R1", {1'b1, 6'd16, 1'b1});

        // R5: line-length sweep
        for (int l = 0; l < 8; l++) begin
            line_len = 3'(l);
            read_check("R5", {1'b0, 6'd16, 1'b1});
        end

        // R7 R5 R6: LOS event, read twice
        pulse(1'b1, 1'b0);
        chk("R7", "int after LOS", int'(int_n), 0);
        read_check("R5", {1'b0, 6'd16, 1'b1});
        read_check("R6", {1'b0, 6'd16, 1'b1});
        chk("R6", "int after reads", int'(int_n), 0);

        // DRV event: code 111
        pulse(1'b0, 1'b1);
        read_check("R5", {1'b0, 6'd16, 1'b1});

        // R3: clear LOS, DRV remains
        write_ctl(8'h01);
        chk("R3", "int with DRV pending", int'(int_n), exp_int());
        read_check("R3", {1'b0, 6'd16, 1'b1});
        pulse(1'b1, 1'b0);
        read_check("R4", {1'b0, 6'd16, 1'b1});

        // R3 R4: clear DRV, unmask LOS
        write_ctl(8'h02);
        chk("R3", "int after clearing DRV", int'(int_n), 1);
        pulse(1'b1, 1'b0);
        chk("R4", "unmasked LOS raises int", int'(int_n), 0);
        read_check("R4", {1'b0, 6'd16, 1'b1});

        // R2: writes to foreign addresses change nothing
        for (int k = 0; k < 4; k++) begin
            int ad;
            ad = (k == 0) ? 0 : (k == 1) ? 17 : (k == 2) ? 48 : 63;
            frame({1'b0, 6'(ad), 1'b0}, 8'h03, 16, rd, a, b, c);
            chk("R2", "int after foreign write", int'(int_n), 0);
        end
        read_check("R2", {1'b0, 6'd16, 1'b1});

        // R9: abort inside write data, then inside command
        frame({1'b0, 6'd16, 1'b0}, 8'h03, 12, rd, a, b, c);
        chk("R9", "int after aborted write", int'(int_n), 0);
        frame({1'b0, 6'd16, 1'b1}, 8'h00, 3, rd, a, b, c);
        chk("R9", "oe after aborted command", c, 0);
        read_check("R9", {1'b0, 6'd16, 1'b1});

        // R4: upper data bits have no effect; sweep low bits with both latched
        for (int d = 0; d < 4; d++) begin
            write_ctl(8'h00);
            pulse(1'b1, 1'b1);
            chk("R7", "both latched int", int'(int_n), 0);
            write_ctl({6'b111111, 2'(d)});
            chk("R3", "int after write sweep", int'(int_n), exp_int());
            read_check("R4", {1'b0, 6'd16, 1'b1});
            pulse(1'b1, 1'b1);
            read_check("R4", {1'b0, 6'd16, 1'b1});
            chk("R7", "int after masked events", int'(int_n), exp_int());
        end

        write_ctl(8'h00);
        read_check("R4", {1'b0, 6'd16, 1'b1});

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule